// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that finishes one instruction in each clock cycle. The core handles register-to-register arithmetic and logic, word loads, word stores and a branch taken when two registers are equal. In one cycle the core fetches an instruction, decodes it and reads its registers, runs the ALU, accesses data memory and writes the result back. Instruction memory and data memory sit outside the core. The core fetches from a word-addressed instruction port and uses a byte-addressed data port for loads and stores. Reads on both ports are combinational. A data write takes effect on the rising edge.

The register file, main decoder, ALU-operation decoder, ALU, immediate sign extender and next-PC logic are all inside the core. The branch decision comes only from the ALU zero flag of a subtraction of the two source registers. The branch target comes from a separate shift-by-two adder that acts on PC+4.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the PC is held at zero. The first instruction after reset is fetched from word address 0.
- R2: An instruction that is not a taken branch moves the PC to PC+4, which is the next word address.
- R3: Opcode 0x00 selects a register operation. Its fields are rs = bits 25:21, rt = bits 20:16, rd = bits 15:11 and function = bits 5:0. The function codes are 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or, and 0x2A signed set-less-than. The result goes to rd.
- R4: Opcode 0x23 loads a word. Bits 15:0 hold a 16-bit offset. The core presents rs plus the sign-extended offset on the data address and writes the returned word to rt.
- R5: Opcode 0x2B stores a word. The core presents rs plus the sign-extended offset on the data address, drives rt onto the write data and raises the write enable. No register changes.
- R6: The core sign-extends the 16-bit offset to 32 bits, so negative load/store offsets and backward branches reach lower addresses.
- R7: Opcode 0x04 is branch-if-equal. When rs minus rt is zero, the next PC is (PC+4) + (offset << 2). Otherwise it is PC+4. A branch writes no register.
- R8: Register 0 always reads as zero. A write aimed at register 0 is discarded.
- R9: The data write enable is high only for a store. An unsupported opcode, or a register operation with an unsupported function code, changes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_waddr | output | IMEM_AW | Word address of the instruction to fetch (PC bits IMEM_AW+1:2) |
| imem_data | input | 32 | Instruction word at `imem_waddr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The bench runs the same test program on every ordered pair taken from a set of operand values. The set includes zero, one, the largest positive value, the most negative value, all-ones and repeated values. A core that compares without sign for set-less-than would get the results wrong when the operand signs differ. A core that takes the branch on the wrong condition would break the fetch sequence on the equal and unequal pairs. The program also contains a negative load offset, a backward branch and a stores from a non-zero base. Dropping the sign extension or the shift by two sends these to the wrong address. Writes to register 0 and instructions with unknown opcodes or function codes are followed by stores that expose the register involved. A core that let any of them through would show a changed value.

// File: rtl/sc_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes a fixed 32-bit instruction format with a 6-bit major opcode.
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int OPC_W  = 6;
    localparam int FUN_W  = 6;
    localparam int IMM_W  = 16;

    typedef enum logic [OPC_W-1:0] {
        OPC_REG   = 6'h00,
        OPC_BEQ   = 6'h04,
        OPC_LOAD  = 6'h23,
        OPC_STORE = 6'h2B
    } opcode_e;

    typedef enum logic [FUN_W-1:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } funct_e;

    // Operation actually performed by the ALU.
    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    // What the main decoder asks of the ALU-operation decoder.
    typedef enum logic [1:0] {
        AK_ADD,
        AK_SUB,
        AK_FUNCT
    } alu_kind_e;

    typedef struct packed {
        logic      reg_write;
        logic      dst_is_rd;
        logic      use_imm;
        logic      mem_write;
        logic      wb_from_mem;
        logic      is_branch;
        alu_kind_e alu_kind;
    } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is a constant zero. Writes to it are dropped.
// Assumes the write is sampled on the rising edge with synchronous active-low reset.
module sc_regfile #(
    parameter int DW    = 32,
    parameter int NREGS = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] regs [NREGS];

    // Register zero is tied off.
    assign regs[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        // Each storage register: clear on reset, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (wa == AW'(g))) begin
                regs[g] <= wd;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        rd1 = regs[ra1];
        rd2 = regs[ra2];
    end

endmodule

// File: rtl/sc_decoder.sv
// Main decoder: maps the major opcode to the datapath controls.
// Unknown opcodes decode to an operation with no side effects.
module sc_decoder
    import sc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    // Opcode-to-control lookup.
    always_comb begin
        ctrl          = '0;
        ctrl.alu_kind = AK_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_kind  = AK_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.use_imm     = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_kind  = AK_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_ctrl.sv
// ALU-operation decoder. It combines the main decoder's request with the function field.
// funct_ok goes low for a register operation whose function code is not supported.
module sc_alu_ctrl
    import sc_pkg::*;
(
    input  alu_kind_e        kind,
    input  logic [FUN_W-1:0] funct,
    output alu_op_e          op,
    output logic             funct_ok
);

    // Choose the ALU operation.
    always_comb begin
        op       = ALU_ADD;
        funct_ok = 1'b1;
        unique case (kind)
            AK_SUB:   op = ALU_SUB;
            AK_FUNCT: begin
                unique case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: funct_ok = 1'b0;
                endcase
            end
            default:  op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Integer ALU with a zero flag taken from the result.
// Set-less-than compares as signed two's-complement.
module sc_alu
    import sc_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);

    // Compute the selected operation.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = DW'($signed(a) < $signed(b));
            default: y = '0;
        endcase
    end

    // Zero flag for the branch decision.
    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top. It holds the PC, fetch addressing, field extraction,
// sign extension, operand and write-back muxes, and the next-PC logic with its own branch adder.
// Assumes combinational instruction and data reads and a data write on the rising clock edge.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 10,
    parameter int NREGS   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IMEM_AW-1:0] imem_waddr,
    input  logic [XLEN-1:0]    imem_data,
    output logic [XLEN-1:0]    dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_we,
    input  logic [XLEN-1:0]    dmem_rdata
);

    localparam int RAW = $clog2(NREGS);

    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  pc_plus4;
    logic [XLEN-1:0]  br_target;
    logic [XLEN-1:0]  pc_next;
    logic [OPC_W-1:0] f_opc;
    logic [FUN_W-1:0] f_fun;
    logic [RAW-1:0]   f_rs;
    logic [RAW-1:0]   f_rt;
    logic [RAW-1:0]   f_rd;
    logic [IMM_W-1:0] f_imm;
    logic [XLEN-1:0]  imm_ext;
    logic [XLEN-1:0]  rs_val;
    logic [XLEN-1:0]  rt_val;
    logic [XLEN-1:0]  alu_b;
    logic [XLEN-1:0]  alu_y;
    logic             alu_zero;
    logic [XLEN-1:0]  wb_data;
    logic [RAW-1:0]   wb_addr;
    logic             wb_en;
    logic             funct_ok;
    ctrl_t            ctrl;
    alu_op_e          alu_op;

    // Split the instruction word into its fields.
    always_comb begin
        f_opc = imem_data[31:26];
        f_rs  = imem_data[21 +: RAW];
        f_rt  = imem_data[16 +: RAW];
        f_rd  = imem_data[11 +: RAW];
        f_fun = imem_data[FUN_W-1:0];
        f_imm = imem_data[IMM_W-1:0];
    end

    // Sign-extend the 16-bit offset.
    assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

    sc_decoder u_dec (
        .opcode (f_opc),
        .ctrl   (ctrl)
    );

    sc_alu_ctrl u_aluc (
        .kind     (ctrl.alu_kind),
        .funct    (f_fun),
        .op       (alu_op),
        .funct_ok (funct_ok)
    );

    sc_regfile #(
        .DW    (XLEN),
        .NREGS (NREGS),
        .AW    (RAW)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (wb_en),
        .wa    (wb_addr),
        .wd    (wb_data)
    );

    // Second ALU operand: register or sign-extended offset.
    assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu #(
        .DW (XLEN)
    ) u_alu (
        .op   (alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory port.
    always_comb begin
        dmem_addr  = alu_y;
        dmem_wdata = rt_val;
        dmem_we    = ctrl.mem_write;
    end

    // Write-back selection. A register operation with an unknown function code is suppressed.
    always_comb begin
        wb_data = ctrl.wb_from_mem ? dmem_rdata : alu_y;
        wb_addr = ctrl.dst_is_rd ? f_rd : f_rt;
        wb_en   = ctrl.reg_write && ((ctrl.alu_kind != AK_FUNCT) || funct_ok);
    end

    // Next PC: sequential or the branch target from the dedicated adder.
    always_comb begin
        pc_plus4  = pc_q + XLEN'(4);
        br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        pc_next   = (ctrl.is_branch && alu_zero) ? br_target : pc_plus4;
    end

    // PC register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign imem_waddr = pc_q[IMEM_AW+1:2];

endmodule

// File: rtl/sc_core_chk.sv
// Property checker for sc_core, attached by bind. It relates the PC, the fetched
// instruction, the register read values and the store strobe across cycles.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        dmem_we
);

    logic [31:0] ofs_sh;
    assign ofs_sh = {{14{instr[15]}}, instr[15:0], 2'b00};

    // R1: the PC leaves reset at zero
    p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == 32'd0));

    // R2: any non-branch opcode steps the PC by four
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] != 6'h04) |=> (pc == $past(pc) + 32'd4));

    // R7: equal operands on a branch reach the target
    p_beq_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[31:26] == 6'h04) && (rs_val == rt_val))
        |=> (pc == $past(pc) + 32'd4 + $past(ofs_sh)));

    // R7: unequal operands on a branch fall through
    p_beq_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[31:26] == 6'h04) && (rs_val != rt_val))
        |=> (pc == $past(pc) + 32'd4));

    // R8: register zero reads as zero
    p_r0_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

    // R9: only a store raises the write strobe
    p_we_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (instr[31:26] == 6'h2B));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc      (pc_q),
    .instr   (imem_data),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .dmem_we (dmem_we)
);

// File: tb/sc_core_bench.sv
// Sweeps a fixed program over every ordered pair of eight operand values. It checks
// the fetch sequence every cycle and every store against arithmetic expectations.
module sc_core_bench;

    localparam int IAW   = 5;
    localparam int NCYC  = 27;
    localparam int NVAL  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [IAW-1:0] imem_waddr;
    logic [31:0]    imem_data;
    logic [31:0]    dmem_addr;
    logic [31:0]    dmem_wdata;
    logic           dmem_we;
    logic [31:0]    dmem_rdata;

    logic [31:0] imem [32];
    logic [31:0] dmem [64];
    logic [31:0] va, vb, sent;
    logic [5:0]  dw;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // 50 MHz: 20 time-unit period
    always #10 clk = ~clk;

    sc_core #(.IMEM_AW(IAW), .NREGS(32)) u_sc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_waddr (imem_waddr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data = imem[imem_waddr];
    assign dw        = dmem_addr[7:2];
    assign dmem_rdata = (dw == 6'd0)  ? va :
                        (dw == 6'd1)  ? vb :
                        (dw == 6'd2)  ? 32'd64 :
                        (dw == 6'd15) ? sent : dmem[dw];

    always @(posedge clk) begin
        if (rst_n && dmem_we) dmem[dw] <= dmem_wdata;
    end

    function automatic logic [31:0] rop(input int rs, rt, rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] iop(input logic [5:0] op, input int rs, rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [31:0] ea [12];
    logic [31:0] ed [12];
    string       er [12];
    int          ne;
    int          epc [NCYC];

    task automatic add_w(input logic [31:0] a, input logic [31:0] d, input string r);
        ea[ne] = a; ed[ne] = d; er[ne] = r; ne++;
    endtask

    task automatic load_program();
        imem[0]  = iop(6'h23, 0, 1, 0);       // R4 lw r1,0(r0)
        imem[1]  = iop(6'h23, 0, 2, 4);
        imem[2]  = iop(6'h23, 0, 9, 8);       // r9 = 64
        imem[3]  = rop(1, 2, 3, 6'h20);       // R3 add
        imem[4]  = iop(6'h2B, 0, 3, 16);
        imem[5]  = rop(1, 2, 3, 6'h22);       // sub
        imem[6]  = iop(6'h2B, 0, 3, 20);
        imem[7]  = rop(1, 2, 3, 6'h24);       // and
        imem[8]  = iop(6'h2B, 0, 3, 24);
        imem[9]  = rop(1, 2, 3, 6'h25);       // or
        imem[10] = iop(6'h2B, 0, 3, 28);
        imem[11] = rop(1, 2, 3, 6'h2A);       // slt
        imem[12] = iop(6'h2B, 0, 3, 32);
        imem[13] = rop(1, 2, 3, 6'h26);       // R9 unsupported function
        imem[14] = iop(6'h08, 1, 3, 5);       // R9 unsupported opcode
        imem[15] = iop(6'h2B, 0, 3, 36);
        imem[16] = rop(1, 2, 0, 6'h20);       // R8 write to r0
        imem[17] = iop(6'h2B, 0, 0, 40);
        imem[18] = iop(6'h23, 9, 5, -4);      // R6 negative offset -> 60
        imem[19] = iop(6'h2B, 9, 5, 4);       // R5 base+offset -> 68
        imem[20] = iop(6'h04, 1, 2, 1);       // R7 forward branch
        imem[21] = iop(6'h2B, 0, 1, 44);
        imem[22] = iop(6'h2B, 0, 2, 48);
        imem[23] = iop(6'h04, 0, 0, -1);      // R6 backward branch onto itself
        for (int i = 24; i < 32; i++) imem[i] = 32'h0;
    endtask

    logic [31:0] vals [NVAL];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'h0000_0002; vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000; vals[5] = 32'hFFFF_FFFF;
        vals[6] = 32'h1234_5678; vals[7] = 32'h1234_5678;
        for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
        va = '0; vb = '0; sent = '0;
        load_program();
        for (int ia = 0; ia < NVAL; ia++) begin
            for (int ib = 0; ib < NVAL; ib++) begin
                logic [31:0] slt_v;
                bit          eq;
                int          wi;
                va   = vals[ia];
                vb   = vals[ib];
                sent = vals[ia] ^ 32'hA5C3_0F96 ^ {24'd0, 4'(ia), 4'(ib)};
                eq   = (va == vb);
                slt_v = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
                ne = 0;
                add_w(32'd16, va + vb, "R3");
                add_w(32'd20, va - vb, "R3");
                add_w(32'd24, va & vb, "R3");
                add_w(32'd28, va | vb, "R3");
                add_w(32'd32, slt_v,   "R3");
                add_w(32'd36, slt_v,   "R9");
                add_w(32'd40, 32'd0,   "R8");
                add_w(32'd68, sent,    "R6");
                if (!eq) add_w(32'd44, va, "R7");
                add_w(32'd48, vb,      "R7");
                for (int c = 0; c < NCYC; c++) begin
                    if (c <= 20)      epc[c] = c;
                    else if (eq)      epc[c] = (c == 21) ? 22 : 23;
                    else              epc[c] = (c == 21) ? 21 : (c == 22) ? 22 : 23;
                end
                rst_n = 1'b0;
                repeat (2) @(negedge clk);
                chk(imem_waddr == '0, "R1", "pc in reset", 32'(imem_waddr), 32'd0);
                rst_n = 1'b1;
                wi = 0;
                for (int c = 0; c < NCYC; c++) begin
                    if (c > 0) @(negedge clk);
                    chk(32'(imem_waddr) == 32'(epc[c]), (c > 20) ? "R7" : "R2",
                        "fetch word", 32'(imem_waddr), 32'(epc[c]));
                    if (dmem_we) begin
                        if (wi < ne) begin
                            chk(dmem_addr == ea[wi], "R5", "store address", dmem_addr, ea[wi]);
                            chk(dmem_wdata == ed[wi], er[wi], "store data", dmem_wdata, ed[wi]);
                        end else begin
                            chk(1'b0, "R9", "unexpected store", dmem_addr, 32'hFFFF_FFFF);
                        end
                        wi++;
                    end
                end
                chk(wi == ne, "R9", "store count", 32'(wi), 32'(ne));
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule